// File: doc/BRIEF.md
# Nibble Stack Frame Controller

This block performs the stack traffic of a 4-bit microcontroller core. It owns the 8-bit stack pointer and drives a nibble-wide stack memory port that has an asynchronous read. It makes exactly one nibble access per clock. The core issues one of five operations with a request strobe and an opcode. The operations are: pushing or popping an 8-bit register pair, pushing or popping the memory-bank/register-bank select pair, and returning from an interrupt.

The interrupt return reads a six-nibble frame. From it the block rebuilds a 13-bit program counter, an 8-bit status word and the two bank-enable flags. The program-counter nibbles sit in the frame out of natural order. The top bit of the counter and both enable flags share one nibble. A mode input chooses whether that nibble's flag bits are restored or whether the flags keep their present values.

When the last access has been made, the block commits the new stack pointer and raises `done` for one cycle. The popped values and the restored values are presented during that cycle. Requests that arrive while an operation runs are ignored. The next operation may be requested during the `done` cycle.

Top module: `nstk_frame_ctrl`

## Requirements
- R1: After reset the stack pointer is SP_RESET (default 8'h00), `done` is 0 and `mem_en` is 0.
- R2: Opcode 0 (pair push) writes rp_in[7:4] to SP-1 and then rp_in[3:0] to SP-2, on consecutive cycles. It then lowers SP by 2.
- R3: Opcode 1 (pair pop) reads SP+1 into rp_out[7:4] and then SP into rp_out[3:0]. It then raises SP by 2.
- R4: Opcode 2 (bank push) writes mbs_in to SP-1 and then rbs_in to SP-2. It then lowers SP by 2.
- R5: Opcode 3 (bank pop) reads SP+1 into mbs_out and then SP into rbs_out. It then raises SP by 2.
- R6: Opcode 4 (interrupt return) reads SP+1, SP, SP+3, SP+2, SP+4 and SP+5, in that order. It sets pc_out[11:8], pc_out[7:4] and pc_out[3:0] from SP, SP+3 and SP+2, and psw_out[7:4] and psw_out[3:0] from SP+4 and SP+5. It then raises SP by 6.
- R7: On an interrupt return with mode_ext=1, mbe_out and rbe_out take bits 3 and 2 of the SP+1 nibble. With mode_ext=0 they equal mbe_in and rbe_in.
- R8: On an interrupt return, pc_out[12] takes bit 0 of the SP+1 nibble in both modes.
- R9: Accesses occur one per cycle, starting in the cycle after the accepting edge. `done` is a one-cycle pulse in the cycle after the last access, and SP changes only into a `done` cycle. A request presented during the `done` cycle is accepted.
- R10: A request while an operation runs does not change its accesses or result. Opcodes 5 to 7 start nothing: no access, no `done`, SP unchanged.
- R11: SP arithmetic and stack addresses wrap modulo 256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Operation request |
| op_code | input | 3 | Operation code (0..4 valid) |
| mode_ext | input | 1 | 1 selects flag restore on interrupt return |
| rp_in | input | 8 | Register pair to push |
| mbs_in | input | 4 | Memory bank select to push |
| rbs_in | input | 4 | Register bank select to push |
| mbe_in | input | 1 | Present memory-bank enable flag |
| rbe_in | input | 1 | Present register-bank enable flag |
| mem_en | output | 1 | Stack memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | SP_W | Stack memory address |
| mem_wdata | output | 4 | Write nibble |
| mem_rdata | input | 4 | Read nibble (same-cycle) |
| sp_out | output | SP_W | Stack pointer |
| rp_out | output | 8 | Popped register pair |
| mbs_out | output | 4 | Popped memory bank select |
| rbs_out | output | 4 | Popped register bank select |
| pc_out | output | PC_W | Restored program counter |
| psw_out | output | 8 | Restored status word |
| mbe_out | output | 1 | Restored memory-bank enable |
| rbe_out | output | 1 | Restored register-bank enable |
| done | output | 1 | Operation complete pulse |

## Verification
The hardest case to reach from the ports is a request that arrives in the middle of an operation. The stimulus keeps req high after acceptance and switches the opcode to an interrupt return while a push is still writing. It drops the request just before the `done` cycle. The access stream must still be exactly the push. Back-to-back operations are issued in the `done` cycle itself. Stack wrap is reached by pushing from the reset pointer of zero. Return frames are placed straddling address zero and later in memory, and are read back in both modes.

// File: rtl/nstk_pkg.sv
package nstk_pkg;

  typedef enum logic [2:0] {
    OP_PUSH_RP = 3'd0,
    OP_POP_RP  = 3'd1,
    OP_PUSH_BS = 3'd2,
    OP_POP_BS  = 3'd3,
    OP_RETI    = 3'd4
  } nstk_op_e;

  localparam int unsigned FRAME_NIB = 6;

  function automatic logic op_known(input logic [2:0] code);
    return code <= 3'd4;
  endfunction

  function automatic logic op_is_push(input nstk_op_e op);
    return (op == OP_PUSH_RP) || (op == OP_PUSH_BS);
  endfunction

  // index of the final access of an operation
  function automatic logic [2:0] op_last_step(input nstk_op_e op);
    return (op == OP_RETI) ? 3'd5 : 3'd1;
  endfunction

  // signed nibble offset from SP for access number 'step'
  function automatic logic [3:0] step_offset(input nstk_op_e op, input logic [2:0] step);
    logic [3:0] off;
    case (op)
      OP_PUSH_RP, OP_PUSH_BS: off = step[0] ? 4'hE : 4'hF;
      OP_POP_RP, OP_POP_BS:   off = step[0] ? 4'h0 : 4'h1;
      default: begin
        case (step)
          3'd0:    off = 4'h1;
          3'd1:    off = 4'h0;
          3'd2:    off = 4'h3;
          3'd3:    off = 4'h2;
          3'd4:    off = 4'h4;
          default: off = 4'h5;
        endcase
      end
    endcase
    return off;
  endfunction

  // signed SP adjustment committed at completion
  function automatic logic [3:0] sp_delta(input nstk_op_e op);
    logic [3:0] d;
    case (op)
      OP_PUSH_RP, OP_PUSH_BS: d = 4'hE;
      OP_POP_RP, OP_POP_BS:   d = 4'h2;
      default:                d = 4'h6;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/nstk_seq.sv
module nstk_seq
  import nstk_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req,
  input  logic [2:0]     op_code,
  input  logic           mode_ext,
  output logic           accept,
  output logic           busy,
  output logic           last,
  output logic [2:0]     step,
  output nstk_op_e       op_q,
  output logic           mode_q,
  output logic           done
);

  logic       busy_q, busy_d;
  logic [2:0] step_q, step_d;
  nstk_op_e   op_d;
  logic       mode_d;
  logic       done_q, done_d;

  assign accept = req && !busy_q && op_known(op_code);
  assign last   = busy_q && (step_q == op_last_step(op_q));

  always_comb begin
    busy_d = busy_q;
    step_d = step_q;
    op_d   = op_q;
    mode_d = mode_q;
    done_d = 1'b0;
    if (accept) begin
      busy_d = 1'b1;
      step_d = 3'd0;
      op_d   = nstk_op_e'(op_code);
      mode_d = mode_ext;
    end else if (last) begin
      busy_d = 1'b0;
      done_d = 1'b1;
    end else if (busy_q) begin
      step_d = step_q + 3'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      step_q <= 3'd0;
      op_q   <= OP_PUSH_RP;
      mode_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      step_q <= step_d;
      op_q   <= op_d;
      mode_q <= mode_d;
      done_q <= done_d;
    end
  end

  assign busy = busy_q;
  assign step = step_q;
  assign done = done_q;

  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  p_hold_op_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !last) |=> (busy_q && $stable(op_q) && $stable(mode_q)));

endmodule

// File: rtl/nstk_addr.sv
module nstk_addr
  import nstk_pkg::*;
#(
  parameter int unsigned SP_W     = 8,
  parameter logic [SP_W-1:0] SP_RESET = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            busy,
  input  logic            last,
  input  logic [2:0]      step,
  input  nstk_op_e        op_q,
  input  logic            done,
  output logic [SP_W-1:0] sp,
  output logic [SP_W-1:0] mem_addr,
  output logic            mem_en,
  output logic            mem_we
);

  localparam int unsigned EXT = SP_W - 4;

  logic [SP_W-1:0] sp_q, sp_d;
  logic [3:0]      off;
  logic [3:0]      dlt;

  assign off = step_offset(op_q, step);
  assign dlt = sp_delta(op_q);

  always_comb begin
    sp_d = sp_q;
    if (last) sp_d = sp_q + {{EXT{dlt[3]}}, dlt};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sp_q <= SP_RESET;
    else        sp_q <= sp_d;
  end

  assign sp       = sp_q;
  assign mem_addr = sp_q + {{EXT{off[3]}}, off};
  assign mem_en   = busy;
  assign mem_we   = busy && op_is_push(op_q);

  p_sp_commit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sp_q) |-> done);

  p_write_below_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> ((mem_addr == sp_q - SP_W'(1)) || (mem_addr == sp_q - SP_W'(2))));

  p_read_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && !mem_we) |-> (SP_W'(mem_addr - sp_q) < SP_W'(FRAME_NIB)));

endmodule

// File: rtl/nstk_capture.sv
module nstk_capture
  import nstk_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       accept,
  input  logic [2:0] op_code,
  input  logic [7:0] rp_in,
  input  logic [3:0] mbs_in,
  input  logic [3:0] rbs_in,
  input  logic       busy,
  input  logic [2:0] step,
  input  nstk_op_e   op_q,
  input  logic [3:0] mem_rdata,
  output logic [3:0] mem_wdata,
  output logic [FRAME_NIB-1:0][3:0] nib
);

  logic [7:0] wd_q, wd_d;
  logic [FRAME_NIB-1:0][3:0] nib_q, nib_d;
  logic       rd_en;

  assign rd_en = busy && !op_is_push(op_q);

  always_comb begin
    wd_d = wd_q;
    if (accept) wd_d = (op_code == OP_PUSH_BS) ? {mbs_in, rbs_in} : rp_in;
  end

  always_comb begin
    nib_d = nib_q;
    for (int i = 0; i < FRAME_NIB; i++) begin
      if (rd_en && (step == 3'(i))) nib_d[i] = mem_rdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wd_q  <= '0;
      nib_q <= '0;
    end else begin
      wd_q  <= wd_d;
      nib_q <= nib_d;
    end
  end

  assign mem_wdata = step[0] ? wd_q[3:0] : wd_q[7:4];
  assign nib       = nib_q;

  p_wdata_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !accept) |=> $stable(wd_q));

endmodule

// File: rtl/nstk_frame_ctrl.sv
module nstk_frame_ctrl
  import nstk_pkg::*;
#(
  parameter int unsigned SP_W     = 8,
  parameter int unsigned PC_W     = 13,
  parameter logic [SP_W-1:0] SP_RESET = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req,
  input  logic [2:0]      op_code,
  input  logic            mode_ext,
  input  logic [7:0]      rp_in,
  input  logic [3:0]      mbs_in,
  input  logic [3:0]      rbs_in,
  input  logic            mbe_in,
  input  logic            rbe_in,
  output logic            mem_en,
  output logic            mem_we,
  output logic [SP_W-1:0] mem_addr,
  output logic [3:0]      mem_wdata,
  input  logic [3:0]      mem_rdata,
  output logic [SP_W-1:0] sp_out,
  output logic [7:0]      rp_out,
  output logic [3:0]      mbs_out,
  output logic [3:0]      rbs_out,
  output logic [PC_W-1:0] pc_out,
  output logic [7:0]      psw_out,
  output logic            mbe_out,
  output logic            rbe_out,
  output logic            done
);

  logic       accept, busy, last, mode_q;
  logic [2:0] step;
  nstk_op_e   op_q;
  logic [FRAME_NIB-1:0][3:0] nib;

  nstk_seq u_seq (
    .clk(clk), .rst_n(rst_n), .req(req), .op_code(op_code), .mode_ext(mode_ext),
    .accept(accept), .busy(busy), .last(last), .step(step), .op_q(op_q),
    .mode_q(mode_q), .done(done)
  );

  nstk_addr #(.SP_W(SP_W), .SP_RESET(SP_RESET)) u_addr (
    .clk(clk), .rst_n(rst_n), .busy(busy), .last(last), .step(step), .op_q(op_q),
    .done(done), .sp(sp_out), .mem_addr(mem_addr), .mem_en(mem_en), .mem_we(mem_we)
  );

  nstk_capture u_cap (
    .clk(clk), .rst_n(rst_n), .accept(accept), .op_code(op_code), .rp_in(rp_in),
    .mbs_in(mbs_in), .rbs_in(rbs_in), .busy(busy), .step(step), .op_q(op_q),
    .mem_rdata(mem_rdata), .mem_wdata(mem_wdata), .nib(nib)
  );

  // nibble 0 is the flag nibble on a return; pairs and banks use 0 (high) and 1 (low)
  assign rp_out  = {nib[0], nib[1]};
  assign mbs_out = nib[0];
  assign rbs_out = nib[1];
  assign psw_out = {nib[4], nib[5]};
  assign mbe_out = mode_q ? nib[0][3] : mbe_in;
  assign rbe_out = mode_q ? nib[0][2] : rbe_in;

  generate
    if (PC_W > 12) begin : g_pc13
      assign pc_out = {{(PC_W-12){1'b0}}, 12'h000} | {{(PC_W-13){1'b0}}, nib[0][0], nib[1], nib[2], nib[3]};
    end else begin : g_pc12
      assign pc_out = PC_W'({nib[1], nib[2], nib[3]});
    end
  endgenerate

  p_no_access_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_en && !accept) |=> !mem_en);

endmodule

// File: tb/nstk_frame_ctrl_tb.sv
module nstk_frame_ctrl_tb;

  logic       clk, rst_n, req, mode_ext, mbe_in, rbe_in;
  logic [2:0] op_code;
  logic [7:0] rp_in;
  logic [3:0] mbs_in, rbs_in;
  logic       mem_en, mem_we, done, mbe_out, rbe_out;
  logic [7:0] mem_addr, sp_out, rp_out, psw_out;
  logic [3:0] mem_wdata, mem_rdata, mbs_out, rbs_out;
  logic [12:0] pc_out;

  int checks = 0;
  int errors = 0;
  logic [7:0] bsp;
  logic [3:0] mem [256];
  logic [12:0] expq [$];   // {we, addr, wdata}

  nstk_frame_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .req(req), .op_code(op_code), .mode_ext(mode_ext),
    .rp_in(rp_in), .mbs_in(mbs_in), .rbs_in(rbs_in), .mbe_in(mbe_in), .rbe_in(rbe_in),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .sp_out(sp_out), .rp_out(rp_out), .mbs_out(mbs_out),
    .rbs_out(rbs_out), .pc_out(pc_out), .psw_out(psw_out), .mbe_out(mbe_out),
    .rbe_out(rbe_out), .done(done)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  assign mem_rdata = mem[mem_addr];
  always @(posedge clk) if (mem_en && mem_we) mem[mem_addr] <= mem_wdata;

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  // monitor: compares each memory access against the scoreboard queue
  always @(negedge clk) begin
    if (rst_n && mem_en) begin
      logic [12:0] e;
      if (expq.size() == 0) begin
        chk("R10 unexpected access", {19'd0, mem_we, mem_addr, mem_wdata}, 32'hFFFF_FFFF);
      end else begin
        e = expq.pop_front();
        chk("R9 access we/addr", {23'd0, mem_we, mem_addr}, {23'd0, e[12], e[11:4]});
        if (e[12]) chk("R2/R4 write data", {28'd0, mem_wdata}, {28'd0, e[3:0]});
      end
    end
  end

  // driver: predicts accesses, issues the request, waits for done
  task automatic do_op(input logic [2:0] op, input logic md, input bit hold_mid);
    int n;
    case (op)
      3'd0: begin expq.push_back({1'b1, bsp - 8'd1, rp_in[7:4]});
                  expq.push_back({1'b1, bsp - 8'd2, rp_in[3:0]}); end
      3'd2: begin expq.push_back({1'b1, bsp - 8'd1, mbs_in});
                  expq.push_back({1'b1, bsp - 8'd2, rbs_in}); end
      3'd1, 3'd3: begin expq.push_back({1'b0, bsp + 8'd1, 4'h0});
                  expq.push_back({1'b0, bsp, 4'h0}); end
      default: begin
        expq.push_back({1'b0, bsp + 8'd1, 4'h0});
        expq.push_back({1'b0, bsp,        4'h0});
        expq.push_back({1'b0, bsp + 8'd3, 4'h0});
        expq.push_back({1'b0, bsp + 8'd2, 4'h0});
        expq.push_back({1'b0, bsp + 8'd4, 4'h0});
        expq.push_back({1'b0, bsp + 8'd5, 4'h0});
      end
    endcase
    op_code  = op;
    mode_ext = md;
    req      = 1'b1;
    @(negedge clk);
    if (hold_mid) begin
      // R10: keep requesting a different operation while busy
      op_code = 3'd4;
      rp_in   = 8'h00;
      @(negedge clk);
      req = 1'b0;
    end else begin
      req = 1'b0;
    end
    n = 0;
    while (!done && n < 20) begin @(negedge clk); n++; end
    chk("R9 done reached", {31'd0, done}, 32'd1);
    case (op)
      3'd0, 3'd2: bsp = bsp - 8'd2;
      3'd1, 3'd3: bsp = bsp + 8'd2;
      default:    bsp = bsp + 8'd6;
    endcase
    chk("R11 sp after op", {24'd0, sp_out}, {24'd0, bsp});
    chk("R9 queue drained", expq.size(), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 4'h0;
    rst_n = 1'b0; req = 1'b0; op_code = 3'd0; mode_ext = 1'b0;
    rp_in = 8'h00; mbs_in = 4'h0; rbs_in = 4'h0; mbe_in = 1'b0; rbe_in = 1'b0;
    bsp = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset sp", {24'd0, sp_out}, 32'h00);
    chk("R1 reset done", {31'd0, done}, 32'd0);
    chk("R1 reset mem_en", {31'd0, mem_en}, 32'd0);

    // R2 + R11: pair push from SP=0 wraps to FF/FE
    rp_in = 8'hA5;
    do_op(3'd0, 1'b0, 1'b0);
    chk("R11 wrapped write FF", {28'd0, mem[8'hFF]}, 32'hA);
    chk("R11 wrapped write FE", {28'd0, mem[8'hFE]}, 32'h5);
    @(negedge clk);
    chk("R9 done single pulse", {31'd0, done}, 32'd0);

    // R4 then R5 issued back-to-back in the done cycle (R9)
    mbs_in = 4'hF; rbs_in = 4'h2;
    do_op(3'd2, 1'b0, 1'b0);
    mbs_in = 4'h0; rbs_in = 4'h0;
    do_op(3'd3, 1'b0, 1'b0);
    chk("R5 mbs popped", {28'd0, mbs_out}, 32'hF);
    chk("R5 rbs popped", {28'd0, rbs_out}, 32'h2);

    // R3: pair pop, SP wraps back to 0
    do_op(3'd1, 1'b0, 1'b0);
    chk("R3 pair popped", {24'd0, rp_out}, 32'hA5);
    @(negedge clk);

    // R10: request held while busy with a different opcode
    rp_in = 8'h3C;
    do_op(3'd0, 1'b0, 1'b1);
    @(negedge clk);
    do_op(3'd1, 1'b0, 1'b0);
    chk("R10 busy request ignored", {24'd0, rp_out}, 32'h3C);
    @(negedge clk);

    // R10: unknown opcode starts nothing
    op_code = 3'd7; req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    begin
      logic seen;
      seen = 1'b0;
      repeat (6) begin @(negedge clk); seen = seen | done; end
      chk("R10 unknown opcode no done", {31'd0, seen}, 32'd0);
    end
    chk("R10 unknown opcode sp", {24'd0, sp_out}, 32'h00);

    // R6, R7, R8: extended-mode return, frame at SP=0
    mem[1] = 4'b1001; mem[0] = 4'h7; mem[3] = 4'hB; mem[2] = 4'h4;
    mem[4] = 4'hD; mem[5] = 4'h6;
    mbe_in = 1'b0; rbe_in = 1'b1;
    do_op(3'd4, 1'b1, 1'b0);
    chk("R6 R8 pc restored", {19'd0, pc_out}, 32'h17B4);
    chk("R6 psw restored", {24'd0, psw_out}, 32'hD6);
    chk("R7 ext mbe", {31'd0, mbe_out}, 32'd1);
    chk("R7 ext rbe", {31'd0, rbe_out}, 32'd0);
    @(negedge clk);

    // R7, R8: basic-mode return, frame at SP=6, flags nibble 1101
    mem[7] = 4'b1101; mem[6] = 4'h2; mem[9] = 4'h8; mem[8] = 4'hE;
    mem[10] = 4'h1; mem[11] = 4'hF;
    mbe_in = 1'b0; rbe_in = 1'b0;
    do_op(3'd4, 1'b0, 1'b0);
    chk("R8 basic pc12", {19'd0, pc_out}, 32'h128E);
    chk("R6 basic psw", {24'd0, psw_out}, 32'h1F);
    chk("R7 basic mbe kept", {31'd0, mbe_out}, 32'd0);
    chk("R7 basic rbe kept", {31'd0, rbe_out}, 32'd0);

    // R6 + R11: return whose frame straddles address zero
    @(negedge clk);
    rp_in = 8'h91;
    do_op(3'd0, 1'b0, 1'b0);
    do_op(3'd0, 1'b0, 1'b0);
    do_op(3'd0, 1'b0, 1'b0);
    do_op(3'd0, 1'b0, 1'b0);
    do_op(3'd0, 1'b0, 1'b0);
    do_op(3'd0, 1'b0, 1'b0);
    do_op(3'd0, 1'b0, 1'b0);
    chk("R11 sp after pushes", {24'd0, sp_out}, 32'hFE);
    mem[8'hFF] = 4'b0100; mem[8'hFE] = 4'hC; mem[8'h01] = 4'h3; mem[8'h00] = 4'h9;
    mem[8'h02] = 4'h5; mem[8'h03] = 4'hA;
    do_op(3'd4, 1'b1, 1'b0);
    chk("R6 wrapped pc", {19'd0, pc_out}, 32'h0C39);
    chk("R6 wrapped psw", {24'd0, psw_out}, 32'h5A);
    chk("R7 wrapped rbe", {31'd0, rbe_out}, 32'd1);

    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule